// File: doc/BRIEF.md
# Quad-Lane Audio Serial Receiver

This block takes stereo serial audio on four data lanes that share one bit clock and one word-select, and turns it into parallel samples. Each lane delivers a 32-bit left sample and a 32-bit right sample, and all four lanes hand over their samples on the same cycle, marked by a one-cycle frame strobe.

The whole block runs on the oversampling master clock, which is typically 256 or 384 times the sample rate. A run-time control picks who owns the serial clocks. As a clock master, the block divides the master clock into a bit clock and divides the bit clock into word-select, then drives both on its outputs. As a clock slave, it synchronises the bit clock and word-select from its pins and detects bit-clock rising edges. In both cases the same deserialiser takes one bit per rising bit-clock edge.

Any change to the dividers or the clock-ownership control restarts the dividers and the deserialiser. Because of this, a frame that was in progress when the settings changed is never reported.

Top module: `aud_lane_rx`

## Requirements
- R1: While reset is held and just after it is released, all sample outputs are zero, `frame_valid_o` is low, and `sck_o`, `ws_o` and `clk_dir_o` are low.
- R2: With `master_i` high, `clk_dir_o` is high and the bit-clock period is `sckdiv_i`+1 master-clock cycles. `sck_o` is high for ceil((`sckdiv_i`+1)/2) cycles of each period. It stays constantly high when `sckdiv_i` is 0.
- R3: With `master_i` high, the word-select period is `wsdiv_i`+1 bit periods. `ws_o` is low for floor((`wsdiv_i`+1)/2) bit periods and high for the rest. `ws_o` changes only at a rising edge of `sck_o`.
- R4: With `master_i` low, the bit clock and word-select come from `sck_i` and `ws_i` through a two-stage synchroniser. `sck_o`, `ws_o` and `clk_dir_o` are held low. Each level of `sck_i` must last at least three master-clock cycles.
- R5: A data bit is taken on each rising bit-clock edge. It belongs to the channel that word-select showed at the previous rising edge, where low means left and high means right. The first bit of a word therefore follows a word-select change by one bit period.
- R6: Bits arrive MSB first. A word shorter than 32 bits is left-justified in its register, and the unused low bits are zero.
- R7: In a word longer than 32 bits, only the first 32 bits are kept and the remaining bits have no effect.
- R8: When a right word completes, and a left word completed just before it, `frame_valid_o` pulses for exactly one cycle. On that same edge all four lanes update `left_o` and `right_o`, with lane n at bits [32n+31:32n]. At all other times the outputs hold their values.
- R9: The word in progress when the receiver first sees a word-select change is discarded. No strobe is given until a complete left word and a complete right word have both been received.
- R10: A change of `sckdiv_i`, `wsdiv_i` or `master_i` restarts the dividers and the deserialiser, and the next cycle has no strobe. The frame that was in progress is never reported, and reporting resumes with the first frame whose left word starts after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Oversampling master clock; clocks the whole block |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: the block generates the bit clock and word-select; 0: it takes them from the pins |
| sckdiv_i | input | 8 | Bit-clock divider; period is value+1 master cycles |
| wsdiv_i | input | 8 | Word-select divider; period is value+1 bit periods |
| sck_i | input | 1 | Bit clock from the pin (slave mode) |
| ws_i | input | 1 | Word-select from the pin (slave mode) |
| sd_i | input | 4 | Serial data, one bit per lane |
| sck_o | output | 1 | Generated bit clock (master mode) |
| ws_o | output | 1 | Generated word-select (master mode) |
| clk_dir_o | output | 1 | Output enable for the bit-clock and word-select pins |
| left_o | output | 128 | Left samples, 32 bits per lane |
| right_o | output | 128 | Right samples, 32 bits per lane |
| frame_valid_o | output | 1 | One-cycle strobe when new samples are presented |

## Verification
In slave mode the bench sends a distinct pseudo-random word to every lane, channel and frame, at word lengths of 8, 24, 32 and 40 bits. This separates left-justification and zero fill from truncation, shows whether lanes or channels are swapped, and confirms that the first partial frame is dropped. One slave run changes a divider in the middle of a left word, and the bench expects exactly that frame to be missing.

In master mode the bench sweeps several pairs of bit-clock and word-select dividers, including a zero bit-clock divider and an odd word-select period. It measures the periods and duty of both generated clocks. In that mode the lanes carry word-select itself, its inverse, a constant one and a constant zero. The resulting words have a single bit set or cleared at a position that depends on the channel lengths, so a one-bit slip in alignment is visible.

// File: rtl/aud_lane_rx.sv
module aud_lane_rx #(
  parameter int LANES = 4,
  parameter int WORD  = 32,
  parameter int DIVW  = 8
) (
  input  logic                   mclk_i,
  input  logic                   rst_ni,
  input  logic                   master_i,
  input  logic [DIVW-1:0]        sckdiv_i,
  input  logic [DIVW-1:0]        wsdiv_i,
  input  logic                   sck_i,
  input  logic                   ws_i,
  input  logic [LANES-1:0]       sd_i,
  output logic                   sck_o,
  output logic                   ws_o,
  output logic                   clk_dir_o,
  output logic [LANES*WORD-1:0]  left_o,
  output logic [LANES*WORD-1:0]  right_o,
  output logic                   frame_valid_o
);

  localparam int CW = $clog2(WORD + 1);

  // configuration shadow and change detect
  logic            master_q;
  logic [DIVW-1:0] sckdiv_q, wsdiv_q;
  logic            chg;

  assign chg = (master_i != master_q) || (sckdiv_i != sckdiv_q) || (wsdiv_i != wsdiv_q);

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      sckdiv_q <= '0;
      wsdiv_q  <= '0;
    end else begin
      master_q <= master_i;
      sckdiv_q <= sckdiv_i;
      wsdiv_q  <= wsdiv_i;
    end
  end

  assign clk_dir_o = master_q;

  // master-mode clock generation
  logic [DIVW-1:0] pc, pc_nx, wcnt, wcnt_nx;
  logic [DIVW:0]   hi, halfw;
  logic            sck_q, ws_q, mtick;

  assign hi      = ({1'b0, sckdiv_q} + (DIVW+1)'(2)) >> 1;
  assign halfw   = ({1'b0, wsdiv_q} + (DIVW+1)'(1)) >> 1;
  assign pc_nx   = (pc == sckdiv_q) ? '0 : pc + 1'b1;
  assign wcnt_nx = (wcnt == wsdiv_q) ? '0 : wcnt + 1'b1;
  assign mtick   = master_q && (pc == sckdiv_q);

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc    <= '0;
      wcnt  <= '0;
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
    end else if (chg || !master_q) begin
      pc    <= '0;
      wcnt  <= '0;
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      pc    <= pc_nx;
      sck_q <= {1'b0, pc_nx} < hi;
      if (mtick) begin
        wcnt <= wcnt_nx;
        ws_q <= {1'b0, wcnt_nx} >= halfw;
      end
    end
  end

  assign sck_o = sck_q;
  assign ws_o  = ws_q;

  // slave-mode pin synchronisers
  logic [2:0]       sck_s;
  logic [1:0]       ws_s;
  logic [LANES-1:0] sd_s1, sd_s2;
  logic             stick;

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s <= '0;
      ws_s  <= '0;
      sd_s1 <= '0;
      sd_s2 <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ws_s  <= {ws_s[0], ws_i};
      sd_s1 <= sd_i;
      sd_s2 <= sd_s1;
    end
  end

  assign stick = !master_q && sck_s[1] && !sck_s[2];

  // shared deserialiser control
  logic             tick, bit_ws;
  logic [LANES-1:0] bits;
  logic             ws_prev, have_prev, synced, have_left, fv_q;
  logic [CW-1:0]    cnt;
  logic             trans, fin_l, fin_r;
  logic [WORD-1:0]  bitpos;

  assign tick   = mtick || stick;
  assign bit_ws = master_q ? ws_q : ws_s[1];
  assign bits   = master_q ? sd_i : sd_s2;
  assign trans  = tick && have_prev && (bit_ws != ws_prev);
  assign fin_l  = trans && synced && !ws_prev;
  assign fin_r  = trans && synced && ws_prev && have_left;
  assign bitpos = (cnt < CW'(WORD)) ? (WORD'(1) << (WORD - 1 - int'(cnt))) : '0;

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_prev   <= 1'b0;
      have_prev <= 1'b0;
      synced    <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
      fv_q      <= 1'b0;
    end else if (chg) begin
      have_prev <= 1'b0;
      synced    <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
      fv_q      <= 1'b0;
    end else begin
      fv_q <= fin_r;
      if (tick) begin
        ws_prev   <= bit_ws;
        have_prev <= 1'b1;
        if (trans) begin
          synced <= 1'b1;
          cnt    <= '0;
        end else if (cnt < CW'(WORD)) begin
          cnt <= cnt + 1'b1;
        end
        if (fin_l) have_left <= 1'b1;
        if (fin_r) have_left <= 1'b0;
      end
    end
  end

  assign frame_valid_o = fv_q;

  // per-lane shift, hold and output registers
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD-1:0] sreg, lhold, lw, rw, done_w;

    assign done_w = sreg | (bits[g] ? bitpos : '0);

    always_ff @(posedge mclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sreg  <= '0;
        lhold <= '0;
        lw    <= '0;
        rw    <= '0;
      end else if (chg) begin
        sreg <= '0;
      end else if (tick) begin
        sreg <= trans ? '0 : done_w;
        if (fin_l) lhold <= done_w;
        if (fin_r) begin
          lw <= lhold;
          rw <= done_w;
        end
      end
    end

    assign left_o[g*WORD +: WORD]  = lw;
    assign right_o[g*WORD +: WORD] = rw;
  end

  // assertions
  p_strobe_single_r8: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  p_outputs_hold_r8: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !frame_valid_o |-> ($stable(left_o) && $stable(right_o)));

  p_cfg_flush_r10: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    chg |=> !frame_valid_o);

  p_slave_quiet_r4: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !clk_dir_o |-> (!sck_o && !ws_o));

  p_ws_on_rise_r3: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (master_q && sckdiv_q != '0 && !$past(chg) && $changed(ws_o)) |-> $rose(sck_o));

  p_count_cap_r7: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    cnt <= CW'(WORD));

endmodule

// File: tb/aud_lane_rx_bench.sv
module aud_lane_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic         mclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         master_i = 1'b0;
  logic [7:0]   sckdiv_i = '0;
  logic [7:0]   wsdiv_i = '0;
  logic         sck_i = 1'b1;
  logic         ws_i = 1'b0;
  logic [3:0]   sd_stream = '0;
  logic [3:0]   sd_bus;
  logic         sck_o, ws_o, clk_dir_o, frame_valid_o;
  logic [127:0] left_o, right_o;

  int n_tests = 0, n_fail = 0;
  bit mode = 0;
  int sc = 0, cur_L = 32, cur_ll = 32, cur_lr = 32;
  int exp_f = 0, exp_end = -1, skip_f = -1, nstrobe = 0;
  int cyc = 0, sck_rise_t = 0, sck_per = 0, sck_hi = 0;
  int ws_rise_t = 0, ws_fall_t = 0, ws_per = 0, ws_lo = 0;
  bit sck_pv = 0, ws_pv = 0, done = 0;
  logic [3:0] pend = '0;

  always #(CLK_PERIOD/2) mclk = ~mclk;

  assign sd_bus = mode ? {1'b0, 1'b1, ~ws_o, ws_o} : sd_stream;

  aud_lane_rx u_aud_lane_rx (
    .mclk_i(mclk), .rst_ni(rst_n), .master_i(master_i), .sckdiv_i(sckdiv_i),
    .wsdiv_i(wsdiv_i), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_bus),
    .sck_o(sck_o), .ws_o(ws_o), .clk_dir_o(clk_dir_o),
    .left_o(left_o), .right_o(right_o), .frame_valid_o(frame_valid_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] wgen(int l, int f, int ch);
    logic [31:0] x;
    x = 32'h9E3779B9 * 32'(sc*64 + f*8 + l*2 + ch + 1);
    return x ^ (x >> 13) ^ 32'h3C5AA5C3;
  endfunction

  function automatic logic [31:0] exp_slave(int l, int f, int ch);
    logic [63:0] m;
    m = (cur_L < 32) ? ~((64'd1 << (32 - cur_L)) - 1) : '1;
    return wgen(l, f, ch) & m[31:0];
  endfunction

  function automatic logic [31:0] exp_master(int l, int ch);
    int L;
    logic [63:0] one_hi, all_but, ones;
    L = ch ? cur_lr : cur_ll;
    one_hi  = 64'd1 << (32 - L);
    all_but = ((64'd1 << L) - 2) << (32 - L);
    ones    = ((64'd1 << L) - 1) << (32 - L);
    case (l)
      0: return ch ? all_but[31:0] : one_hi[31:0];
      1: return ch ? one_hi[31:0] : all_but[31:0];
      2: return ones[31:0];
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge mclk) begin
    cyc++;
    if (sck_o && !sck_pv) begin sck_per = cyc - sck_rise_t; sck_rise_t = cyc; end
    if (!sck_o && sck_pv) sck_hi = cyc - sck_rise_t;
    if (ws_o && !ws_pv) begin ws_per = cyc - ws_rise_t; ws_lo = cyc - ws_fall_t; ws_rise_t = cyc; end
    if (!ws_o && ws_pv) ws_fall_t = cyc;
    sck_pv = sck_o;
    ws_pv = ws_o;
    if (frame_valid_o) begin
      nstrobe++;
      if (mode) begin
        for (int l = 0; l < 4; l++) begin
          check("R3/R5/R8 master left", left_o[l*32 +: 32], exp_master(l, 0));
          check("R3/R5/R8 master right", right_o[l*32 +: 32], exp_master(l, 1));
        end
      end else if (exp_f > exp_end) begin
        check("R9/R10 unexpected strobe", 1, 0);
      end else begin
        for (int l = 0; l < 4; l++) begin
          check("R5/R6/R7/R8 slave left", left_o[l*32 +: 32], exp_slave(l, exp_f, 0));
          check("R5/R6/R7/R8 slave right", right_o[l*32 +: 32], exp_slave(l, exp_f, 1));
        end
        exp_f++;
        if (exp_f == skip_f) exp_f++;
      end
    end
  end

  task automatic slot(input logic c, input logic [3:0] b);
    @(negedge mclk);
    sck_i = 1'b0;
    ws_i = c;
    sd_stream = pend;
    repeat (4) @(negedge mclk);
    sck_i = 1'b1;
    repeat (3) @(negedge mclk);
    pend = b;
  endtask

  task automatic send_frame(input int f, input int L, input bit poke);
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < L; i++) begin
        logic [3:0] b;
        for (int l = 0; l < 4; l++) begin
          logic [31:0] wv;
          wv = wgen(l, f, ch);
          b[l] = (i < 32) ? wv[31 - i] : 1'b1;
        end
        if (poke && ch == 0 && i == L/2) sckdiv_i = sckdiv_i + 8'd1;
        slot(ch[0], b);
      end
    end
  endtask

  task automatic run_slave(input int L, input int F, input int skip);
    @(negedge mclk);
    sc++;
    master_i = 1'b0;
    sckdiv_i = sckdiv_i + 8'd1;
    repeat (4) @(negedge mclk);
    mode = 0;
    cur_L = L;
    exp_f = 1;
    exp_end = F - 1;
    skip_f = skip;
    pend = '0;
    for (int f = 0; f <= F; f++) send_frame(f, L, f == skip);
    repeat (20) @(negedge mclk);
    check("R9 all frames delivered", 64'(exp_f), 64'(exp_end + 1));
    check("R4 slave pins quiet", {61'd0, sck_o, ws_o, clk_dir_o}, 64'd0);
  endtask

  task automatic run_master(input int n, input int w);
    @(negedge mclk);
    mode = 1;
    master_i = 1'b1;
    sckdiv_i = 8'(n);
    wsdiv_i = 8'(w);
    cur_ll = (w + 1) / 2;
    cur_lr = w + 1 - cur_ll;
    nstrobe = 0;
    wait (nstrobe >= 3);
    @(negedge mclk);
    check("R2 direction", 64'(clk_dir_o), 64'd1);
    if (n == 0) check("R2 constant bit clock", 64'(sck_o), 64'd1);
    else begin
      check("R2 bit clock period", 64'(sck_per), 64'(n + 1));
      check("R2 bit clock high time", 64'(sck_hi), 64'((n + 2) / 2));
    end
    check("R3 word-select period", 64'(ws_per), 64'((w + 1) * (n + 1)));
    check("R3 word-select low time", 64'(ws_lo), 64'(cur_ll * (n + 1)));
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    n_fail++;
    $display("FAIL watchdog R8: actual hung expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge mclk);
    check("R1 outputs in reset", {left_o, right_o} == '0 ? 64'd0 : 64'd1, 64'd0);
    check("R1 pins in reset", {60'd0, sck_o, ws_o, clk_dir_o, frame_valid_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge mclk);
    check("R1 outputs after reset", {left_o, right_o} == '0 ? 64'd0 : 64'd1, 64'd0);
    check("R1 pins after reset", {60'd0, sck_o, ws_o, clk_dir_o, frame_valid_o}, 64'd0);

    run_slave(32, 3, -1);
    run_slave(24, 3, -1);
    run_slave(40, 3, -1);
    run_slave(8, 3, -1);
    run_slave(32, 4, 2);

    run_master(1, 63);
    run_master(0, 63);
    run_master(2, 47);
    run_master(3, 31);
    run_master(1, 40);
    run_master(7, 15);

    @(negedge mclk);
    master_i = 1'b0;
    repeat (3) @(negedge mclk);
    mode = 0;
    check("R4 pins quiet after leaving master", {61'd0, sck_o, ws_o, clk_dir_o}, 64'd0);
    run_slave(16, 3, -1);

    finish_up();
  end
endmodule